// File: doc/BRIEF.md
# Prioritized Interrupt Controller with DMA Steering

This block collects interrupt requests from 36 maskable peripheral sources and two non-maskable sources: an external NMI pin and a watchdog. Each source has a one-bit latched request flag. Each maskable source also has a 3-bit level that software programs through a small byte-wide register port. Every cycle the controller finds the pending request with the highest level. Equal levels go to the lowest vector. The winner's level and vector are presented to the CPU, and the CPU acknowledges by taking that vector.

Four start-vector registers can steer matching sources to a DMA engine. A steered source takes no part in CPU arbitration. Its pending flag raises the DMA request line of the register that matched. The flag is cleared when the engine accepts the request or ends the burst. Software can also clear any flag by writing that channel's vector to a clear-command address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every flag, level and start-vector register reads as zero, and `level_o`, `vec_o` and `dma_req_o` are all zero.
- R2: Priority byte b sits at address b (0 to 17). Bits 2:0 hold the level of channel 2b and bits 6:4 hold the level of channel 2b+1. Bit 3 reads the flag of channel 2b and bit 7 reads the flag of channel 2b+1. Writes to bits 3 and 7 are ignored.
- R3: A one-cycle pulse on `req_i[k]` sets the flag of channel k. A channel whose level is 0 or 7 is never presented to the CPU, but its flag still reads back as set.
- R4: `level_o` and `vec_o` are registered. They show the highest pending level one cycle after any flag or level change, and they read 0/0 when nothing is pending.
- R5: Vectors are fixed: NMI is 1, watchdog is 2, and maskable channel k is k+3. Among equal levels the lowest vector wins.
- R6: NMI and watchdog requests always present level 7 and beat every maskable channel.
- R7: A pulse on `ack_i` clears the flag of the channel whose vector is on `vec_o`.
- R8: Writing a vector value to address 22 clears the flag of the channel with that vector.
- R9: Addresses 18 to 21 hold start vectors 0 to 3, and the value 0 matches nothing. A maskable channel whose vector equals start vector j is kept out of CPU arbitration. While its flag is set, `dma_req_o[j]` is high.
- R10: A pulse on `dma_ack_i[j]` or on `dma_end_i[j]` clears the flag of the channel steered to start vector j.
- R11: A request pulse that arrives in the same cycle as a clear event for the same channel leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 36 | Peripheral request pulses, one per maskable channel |
| nmi_i | input | 1 | Non-maskable pin request pulse |
| wdt_i | input | 1 | Watchdog request pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| ack_i | input | 1 | CPU takes the presented vector |
| level_o | output | 3 | Presented level, 0 when idle |
| vec_o | output | 8 | Presented vector, 0 when idle |
| dma_req_o | output | 4 | DMA request, one per start-vector register |
| dma_ack_i | input | 4 | DMA engine accepted the request |
| dma_end_i | input | 4 | DMA burst for that start vector ended |

## Verification
A flag stuck high shows up two cycles after the event that should have cleared it: its channel keeps its vector on `vec_o`, and its bit stays set in the priority byte readback. A flag that is lost, or a wrong level inside the arbiter, changes `level_o`/`vec_o` one cycle after the flag settles. A steering fault makes the same source appear on the CPU outputs and on a DMA line together, or on neither, within two cycles of the request pulse. The bench reads every one of these conditions back at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [2:0] lvl_t;
  typedef logic [7:0] vec_t;
  localparam lvl_t LVL_FIXED   = 3'd7;
  localparam int   CH_VEC_OFS  = 3;   // vector of maskable channel k = k + 3
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_IDX = 38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IDX-1:0] set_i,
  input  logic [N_IDX-1:0] clr_i,
  output logic [N_IDX-1:0] flag_o
);
  for (genvar g = 0; g < N_IDX; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;   // set beats clear
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    // covers R7, R8 and R10 clear paths
    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/irq_pri_regs.sv
module irq_pri_regs
  import irq_pkg::*;
#(
  parameter int N_SRC  = 36,
  parameter int N_DMA  = 4,
  parameter int ADDR_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  input  logic [N_SRC-1:0]     flag_i,
  output lvl_t [N_SRC-1:0]     lvl_o,
  output vec_t [N_DMA-1:0]     dma_vec_o,
  output logic                 clr_cmd_o,
  output vec_t                 clr_vec_o,
  output logic [7:0]           rdata_o
);
  localparam int PRI_BYTES = N_SRC / 2;
  localparam int CLR_ADDR  = PRI_BYTES + N_DMA;

  lvl_t [N_SRC-1:0] lvl_q;
  vec_t [N_DMA-1:0] dvec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      dvec_q <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < PRI_BYTES; b++) begin
        if (addr_i == ADDR_W'(b)) begin
          lvl_q[2*b]   <= wdata_i[2:0];
          lvl_q[2*b+1] <= wdata_i[6:4];
        end
      end
      for (int j = 0; j < N_DMA; j++) begin
        if (addr_i == ADDR_W'(PRI_BYTES + j)) dvec_q[j] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < PRI_BYTES; b++) begin
      if (addr_i == ADDR_W'(b))
        rdata_o = {flag_i[2*b+1], lvl_q[2*b+1], flag_i[2*b], lvl_q[2*b]};
    end
    for (int j = 0; j < N_DMA; j++) begin
      if (addr_i == ADDR_W'(PRI_BYTES + j)) rdata_o = dvec_q[j];
    end
  end

  assign clr_cmd_o = wr_en_i && (addr_i == ADDR_W'(CLR_ADDR));
  assign clr_vec_o = wdata_i;
  assign lvl_o     = lvl_q;
  assign dma_vec_o = dvec_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_IDX = 38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lvl_t [N_IDX-1:0] eff_lvl_i,
  output lvl_t             level_o,
  output vec_t             vec_o
);
  localparam int IDX_W = $clog2(N_IDX);

  lvl_t             best_lvl;
  logic [IDX_W-1:0] best_idx;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_IDX; i++) begin
      if (eff_lvl_i[i] > best_lvl) begin
        best_lvl = eff_lvl_i[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
      vec_o   <= '0;
    end else begin
      level_o <= best_lvl;
      vec_o   <= (best_lvl != '0) ? vec_t'(best_idx) + 8'd1 : '0;
    end
  end

  assert_idle_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) == (vec_o == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC  = 36,
  parameter int N_DMA  = 4,
  parameter int ADDR_W = $clog2(N_SRC / 2 + N_DMA + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              nmi_i,
  input  logic              wdt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ack_i,
  output logic [2:0]        level_o,
  output logic [7:0]        vec_o,
  output logic [N_DMA-1:0]  dma_req_o,
  input  logic [N_DMA-1:0]  dma_ack_i,
  input  logic [N_DMA-1:0]  dma_end_i
);
  localparam int N_IDX = N_SRC + 2;  // idx 0 NMI, 1 watchdog, 2+k channel k

  logic [N_IDX-1:0] flag, set_v, clr_v;
  lvl_t [N_SRC-1:0] lvl;
  vec_t [N_DMA-1:0] dma_vec;
  lvl_t [N_IDX-1:0] eff_lvl;
  logic [N_SRC-1:0] steer, dma_clr;
  logic             clr_cmd;
  vec_t             clr_vec;

  irq_pri_regs #(.N_SRC(N_SRC), .N_DMA(N_DMA), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .flag_i(flag[N_IDX-1:2]), .lvl_o(lvl), .dma_vec_o(dma_vec),
    .clr_cmd_o(clr_cmd), .clr_vec_o(clr_vec), .rdata_o
  );

  always_comb begin
    steer     = '0;
    dma_clr   = '0;
    dma_req_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      for (int j = 0; j < N_DMA; j++) begin
        if (dma_vec[j] == vec_t'(k + CH_VEC_OFS)) begin
          steer[k] = 1'b1;
          if (dma_ack_i[j] || dma_end_i[j]) dma_clr[k] = 1'b1;
          if (flag[k+2]) dma_req_o[j] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    eff_lvl[0] = flag[0] ? LVL_FIXED : '0;
    eff_lvl[1] = flag[1] ? LVL_FIXED : '0;
    for (int k = 0; k < N_SRC; k++) begin
      eff_lvl[k+2] = (flag[k+2] && !steer[k] && lvl[k] != '0 && lvl[k] != LVL_FIXED)
                     ? lvl[k] : '0;
    end
  end

  assign set_v = {req_i, wdt_i, nmi_i};

  always_comb begin
    for (int i = 0; i < N_IDX; i++) begin
      clr_v[i] = (ack_i && vec_o == vec_t'(i + 1)) || (clr_cmd && clr_vec == vec_t'(i + 1));
    end
    for (int k = 0; k < N_SRC; k++) clr_v[k+2] = clr_v[k+2] || dma_clr[k];
  end

  irq_flag_bank #(.N_IDX(N_IDX)) u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .flag_o(flag)
  );

  irq_arbiter #(.N_IDX(N_IDX)) u_arb (
    .clk_i, .rst_ni, .eff_lvl_i(eff_lvl), .level_o, .vec_o
  );

  assert_fixed_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LVL_FIXED) |-> (vec_o == 8'd1 || vec_o == 8'd2));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [35:0] req_i = '0;
  logic        nmi_i = 1'b0, wdt_i = 1'b0, wr_en_i = 1'b0, ack_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, vec_o;
  logic [2:0]  level_o;
  logic [3:0]  dma_req_o;
  logic [3:0]  dma_ack_i = '0, dma_end_i = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  irq_prio_ctrl u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = 5'(a); wdata_i = 8'(d);
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    addr_i = 5'(a); #1;
    chk(req, int'(rdata_o), exp);
  endtask

  task automatic pulse(int ch);
    @(negedge clk_i); req_i[ch] = 1'b1;
    @(negedge clk_i); req_i[ch] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic out_chk(string req, int l, int v);
    @(negedge clk_i);
    chk(req, int'(level_o), l);
    chk(req, int'(vec_o), v);
  endtask

  task automatic t_reset();
    chk("R1", int'(level_o), 0); chk("R1", int'(vec_o), 0);
    chk("R1", int'(dma_req_o), 0);
    rd_chk("R1", 0, 0); rd_chk("R1", 18, 0);
  endtask

  task automatic t_regs();
    wr(0, 8'hFF); rd_chk("R2", 0, 8'h77);
    wr(0, 8'h00); rd_chk("R2", 0, 8'h00);
  endtask

  task automatic t_single();
    wr(2, 8'h30); pulse(5);
    rd_chk("R2", 2, 8'hB0);
    out_chk("R4", 3, 8);
    ack(); out_chk("R7", 0, 0);
    rd_chk("R7", 2, 8'h30);
  endtask

  task automatic t_disabled();
    wr(3, 8'h07); pulse(6);
    out_chk("R3", 0, 0); rd_chk("R3", 3, 8'h0F);
    wr(3, 8'h00); out_chk("R3", 0, 0);
    wr(22, 9); rd_chk("R8", 3, 8'h00);
  endtask

  task automatic t_prio();
    wr(5, 8'h02); wr(10, 8'h05);
    pulse(10); pulse(20); out_chk("R4", 5, 23);
    wr(10, 8'h01); out_chk("R4", 2, 13);
    wr(22, 13); out_chk("R8", 1, 23);
    wr(22, 23); out_chk("R8", 0, 0);
  endtask

  task automatic t_tie();
    wr(2, 8'h04); wr(15, 8'h04);
    pulse(30); pulse(4); out_chk("R5", 4, 7);
    ack(); out_chk("R5", 4, 33);
    ack(); out_chk("R5", 0, 0);
  endtask

  task automatic t_nmi();
    wr(0, 8'h60); pulse(1);
    @(negedge clk_i); wdt_i = 1'b1; nmi_i = 1'b1;
    @(negedge clk_i); wdt_i = 1'b0; nmi_i = 1'b0;
    out_chk("R6", 7, 1);
    ack(); out_chk("R6", 7, 2);
    ack(); out_chk("R6", 6, 4);
    ack(); out_chk("R7", 0, 0);
  endtask

  task automatic t_dma();
    wr(6, 8'h03); wr(19, 15); rd_chk("R9", 19, 15);
    pulse(12); chk("R9", int'(dma_req_o), 4'b0010);
    out_chk("R9", 0, 0);
    @(negedge clk_i); dma_ack_i[1] = 1'b1;
    @(negedge clk_i); dma_ack_i[1] = 1'b0;
    chk("R10", int'(dma_req_o), 0); rd_chk("R10", 6, 8'h03);
    pulse(12); chk("R10", int'(dma_req_o), 4'b0010);
    @(negedge clk_i); dma_end_i[1] = 1'b1;
    @(negedge clk_i); dma_end_i[1] = 1'b0;
    chk("R10", int'(dma_req_o), 0);
    wr(19, 0); pulse(12);
    chk("R9", int'(dma_req_o), 0); out_chk("R9", 3, 15);
  endtask

  task automatic t_setwins();
    @(negedge clk_i); req_i[12] = 1'b1; ack_i = 1'b1;
    @(negedge clk_i); req_i[12] = 1'b0; ack_i = 1'b0;
    out_chk("R11", 3, 15); rd_chk("R11", 6, 8'h0B);
    wr(22, 15); out_chk("R8", 0, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=%0d exp<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_single();
    t_disabled();
    t_prio();
    t_tie();
    t_nmi();
    t_dma();
    t_setwins();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule